// File: doc/BRIEF.md
# External Interrupt Source Controller

The block takes two asynchronous external interrupt lines and turns each into a status bit, according to a per-source configuration word. Each line passes through a two-flop synchronizer. An optional glitch filter then passes a new value only once it has been steady for a selectable number of cycles. A detector follows, set either for edges or for levels, with selectable polarity. The status bits are combined into a single interrupt request.

Software works through a simple single-cycle register bus. Word 0x00 holds a global write-protect bit. Words 0x04 and 0x08 hold the configuration of source 0 and source 1. Word 0x0C reads the status bits, and writing 1 to a bit of it clears that bit. A source's configuration word can lock itself until the next hardware reset. The global write-protect bit can also hold off changes temporarily.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, both configuration words, the write-protect word and the status word read 0, and `irq_o` is 0.
- R2: A configuration word stores only bit 31 (lock), bit 16 (enable), bit 9 (level mode), bit 8 (polarity), bit 4 (filter enable) and bits 1:0 (filter length select). Every other bit reads 0, whatever is written.
- R3: While bit 0 of word 0x00 is 1, writes to either configuration word are dropped. Word 0x00 itself stays writable at all times.
- R4: Once a configuration word holds bit 31 = 1, it ignores all writes until `rst_ni` is asserted. The locked settings keep working.
- R5: A source whose enable bit is 0 never sets its status bit, in either detection mode.
- R6: In edge mode (bit 9 = 0) with the source enabled, the status bit is set by a rising edge when bit 8 = 1, or by a falling edge when bit 8 = 0. It stays set after the input returns.
- R7: Writing 1 to bit x of word 0x0C clears the edge-mode status of source x. Writing 0 to a bit leaves it unchanged.
- R8: In level mode (bit 9 = 1) with the source enabled, the status bit follows the input: it is 1 while the input is high (bit 8 = 1) or low (bit 8 = 0). A clear write does not remove it.
- R9: With bit 4 = 1, an input pulse shorter than 2^(sel+1) cycles (sel = bits 1:0) never reaches the detector, and a longer pulse does. With bit 4 = 0, even a 2-cycle pulse is detected.
- R10: `irq_o` is 1 exactly when at least one status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Byte address of the register word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| src_i | input | 2 | Asynchronous external interrupt inputs |
| status_o | output | 2 | Per-source status |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is the glitch filter's pass/reject boundary. A pulse must be held for a known number of cycles after synchronization, and its result can only be seen later through a sticky edge status. The bench drives pulses a whole number of clock periods long from negedge-aligned tasks. It sends a 2-cycle pulse into a 4-cycle filter and then a 12-cycle pulse, and it reads the status only after a settle time much longer than the synchronizer and filter latency. The lock test also needs a mid-run hardware reset, so that it can show the lock disappears only then.

// File: rtl/ext_irq_pkg.sv
`timescale 1ns/1ps
package ext_irq_pkg;
  localparam int unsigned CFG_W      = 32;
  localparam int unsigned LOCK_BIT   = 31;
  localparam int unsigned EN_BIT     = 16;
  localparam int unsigned LVL_BIT    = 9;
  localparam int unsigned POL_BIT    = 8;
  localparam int unsigned GFEN_BIT   = 4;
  localparam int unsigned SEL_W      = 2;
  localparam logic [CFG_W-1:0] CFG_MASK = 32'h8001_0313;
  // longest filter window is 2^(2^SEL_W) cycles
  localparam int unsigned FCNT_W     = 2**SEL_W;

  typedef struct packed {
    logic             lock;
    logic             en;
    logic             lvl;
    logic             pol;
    logic             gfen;
    logic [SEL_W-1:0] sel;
  } src_cfg_t;

  function automatic src_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    src_cfg_t c;
    c.lock = w[LOCK_BIT];
    c.en   = w[EN_BIT];
    c.lvl  = w[LVL_BIT];
    c.pol  = w[POL_BIT];
    c.gfen = w[GFEN_BIT];
    c.sel  = w[SEL_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/irq_glitch_filter.sv
`timescale 1ns/1ps
module irq_glitch_filter
  import ext_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             d_i,
  output logic             q_o
);
  logic              filt_q;
  logic [FCNT_W-1:0] cnt_q;
  logic [FCNT_W-1:0] lim;

  // new value accepted on the 2^(sel+1)-th consecutive differing cycle
  assign lim = FCNT_W'((1 << (sel_i + 1)) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!en_i) begin
      filt_q <= d_i;
      cnt_q  <= '0;
    end else if (d_i == filt_q) begin
      cnt_q  <= '0;
    end else if (cnt_q == lim) begin
      filt_q <= d_i;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign q_o = en_i ? filt_q : d_i;
endmodule

// File: rtl/irq_detect.sv
`timescale 1ns/1ps
module irq_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic lvl_i,
  input  logic pol_i,
  input  logic sig_i,
  input  logic clr_i,
  output logic status_o
);
  logic prev_q, st_q, hit_edge;

  assign hit_edge = pol_i ? (sig_i & ~prev_q) : (~sig_i & prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      st_q   <= 1'b0;
    end else begin
      prev_q <= sig_i;
      if (lvl_i)                st_q <= en_i & (sig_i == pol_i);
      else if (en_i & hit_edge) st_q <= 1'b1;
      else if (clr_i)           st_q <= 1'b0;
    end
  end

  assign status_o = st_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
`timescale 1ns/1ps
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned NSRC   = 2,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CFG_W-1:0]  bus_wdata_i,
  output logic [CFG_W-1:0]  bus_rdata_o,
  input  logic [NSRC-1:0]   src_i,
  output logic [NSRC-1:0]   status_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] WP_ADDR   = '0;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(4 * (NSRC + 1));

  logic              wp_q;
  logic [CFG_W-1:0]  cfg_q [NSRC];
  logic [NSRC-1:0]   clr;
  logic [NSRC-1:0]   st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                wp_q <= 1'b0;
    else if (bus_we_i && bus_addr_i == WP_ADDR) wp_q <= bus_wdata_i[0];
  end

  assign clr = (bus_we_i && bus_addr_i == STAT_ADDR) ? bus_wdata_i[NSRC-1:0] : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic     hit, take, s_sync, s_filt;
    src_cfg_t c;

    assign hit  = bus_we_i && (bus_addr_i == ADDR_W'(4 * (i + 1)));
    assign take = hit & ~wp_q & ~cfg_q[i][LOCK_BIT];
    assign c    = unpack_cfg(cfg_q[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   cfg_q[i] <= '0;
      else if (take) cfg_q[i] <= bus_wdata_i & CFG_MASK;
    end

    irq_sync #(.STAGES(2)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (src_i[i]),
      .q_o   (s_sync)
    );

    irq_glitch_filter u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (c.gfen),
      .sel_i (c.sel),
      .d_i   (s_sync),
      .q_o   (s_filt)
    );

    irq_detect u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (c.en),
      .lvl_i   (c.lvl),
      .pol_i   (c.pol),
      .sig_i   (s_filt),
      .clr_i   (clr[i]),
      .status_o(st[i])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == WP_ADDR)   bus_rdata_o = {{(CFG_W-1){1'b0}}, wp_q};
    if (bus_addr_i == STAT_ADDR) bus_rdata_o = CFG_W'(st);
    for (int i = 0; i < NSRC; i++)
      if (bus_addr_i == ADDR_W'(4 * (i + 1))) bus_rdata_o = cfg_q[i];
  end

  assign status_o = st;
  assign irq_o    = |st;
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
`timescale 1ns/1ps
module ext_irq_ctrl_chk
  import ext_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wp_i,
  input logic [CFG_W-1:0] cfg0_i,
  input logic [CFG_W-1:0] cfg1_i,
  input logic [1:0]       status_i
);
  // R2
  cfg_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg0_i | cfg1_i) & ~CFG_MASK) == '0);

  // R3
  wp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i |=> ($stable(cfg0_i) && $stable(cfg1_i)));

  // R4
  lock0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg0_i[LOCK_BIT] |=> $stable(cfg0_i));

  // R4
  lock1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg1_i[LOCK_BIT] |=> $stable(cfg1_i));

  // R5
  dis0_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg0_i[EN_BIT] && !status_i[0]) |=> !status_i[0]);

  // R5
  dis1_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg1_i[EN_BIT] && !status_i[1]) |=> !status_i[1]);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wp_i    (wp_q),
  .cfg0_i  (cfg_q[0]),
  .cfg1_i  (cfg_q[1]),
  .status_i(status_o)
);

// File: tb/sim_ext_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ext_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  src = '0;
  logic [1:0]  status;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ext_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .src_i(src),
    .status_o(status), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
  endtask

  task automatic t_reset_regs();
    logic [31:0] v;
    do_reset();
    rd(8'h04, v); check("R1 cfg0", v, 0);
    rd(8'h08, v); check("R1 cfg1", v, 0);
    rd(8'h00, v); check("R1 wp", v, 0);
    rd(8'h0C, v); check("R1 status", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    wr(8'h08, 32'h7FFF_FFFF);
    rd(8'h08, v); check("R2 mask", v, 32'h0001_0313);
    wr(8'h08, 32'h0000_0000);
    rd(8'h08, v); check("R2 rewrite", v, 0);
  endtask

  task automatic t_wp();
    logic [31:0] v;
    wr(8'h00, 32'h1);
    rd(8'h00, v); check("R3 wp set", v, 1);
    wr(8'h04, 32'h0001_0100);
    rd(8'h04, v); check("R3 blocked", v, 0);
    wr(8'h00, 32'h0);
    rd(8'h00, v); check("R3 wp clear", v, 0);
    wr(8'h04, 32'h0001_0100);
    rd(8'h04, v); check("R3 allowed", v, 32'h0001_0100);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_edge();
    wr(8'h04, 32'h0001_0100);  // src0: enabled, edge, rising
    cycles(4);
    src[0] = 1'b1; cycles(6);
    check("R6 rising", status, 2'b01);
    check("R10 irq on", irq, 1);
    src[0] = 1'b0; cycles(6);
    check("R6 sticky", status, 2'b01);
    wr(8'h0C, 32'h2); cycles(2);
    check("R7 other bit", status, 2'b01);
    wr(8'h0C, 32'h1); cycles(2);
    check("R7 clear", status, 2'b00);
    check("R10 irq off", irq, 0);
    wr(8'h08, 32'h0001_0000);  // src1: enabled, edge, falling
    cycles(4);
    src[1] = 1'b1; cycles(6);
    check("R6 rise ignored", status, 2'b00);
    src[1] = 1'b0; cycles(6);
    check("R6 falling", status, 2'b10);
    check("R10 irq src1", irq, 1);
    wr(8'h0C, 32'h2); cycles(2);
    check("R7 clear src1", status, 2'b00);
    wr(8'h04, 32'h0);
    wr(8'h08, 32'h0);
  endtask

  task automatic t_disable();
    wr(8'h04, 32'h0000_0100);  // edge rising, disabled
    cycles(4);
    src[0] = 1'b1; cycles(6);
    src[0] = 1'b0; cycles(6);
    check("R5 edge disabled", status, 2'b00);
    wr(8'h04, 32'h0000_0300);  // level high, disabled
    src[0] = 1'b1; cycles(6);
    check("R5 level disabled", status, 2'b00);
    src[0] = 1'b0; cycles(6);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_level();
    wr(8'h04, 32'h0001_0300);  // level, active high
    cycles(6);
    check("R8 low idle", status, 2'b00);
    src[0] = 1'b1; cycles(6);
    check("R8 high", status, 2'b01);
    wr(8'h0C, 32'h1); cycles(2);
    check("R8 clear ignored", status, 2'b01);
    src[0] = 1'b0; cycles(6);
    check("R8 follows", status, 2'b00);
    wr(8'h04, 32'h0001_0200);  // level, active low
    cycles(4);
    check("R8 active low", status, 2'b01);
    wr(8'h04, 32'h0000_0200);
    cycles(3);
    check("R5 level off", status, 2'b00);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_filter();
    wr(8'h04, 32'h0001_0111);  // rising edge, filter on, 4-cycle window
    cycles(4);
    src[0] = 1'b1; cycles(2); src[0] = 1'b0;
    cycles(12);
    check("R9 short pulse rejected", status, 2'b00);
    src[0] = 1'b1; cycles(12); src[0] = 1'b0;
    cycles(20);
    check("R9 long pulse passed", status, 2'b01);
    wr(8'h0C, 32'h1); cycles(2);
    wr(8'h04, 32'h0001_0100);  // filter off
    cycles(4);
    src[0] = 1'b1; cycles(2); src[0] = 1'b0;
    cycles(8);
    check("R9 unfiltered pulse", status, 2'b01);
    wr(8'h0C, 32'h1); cycles(2);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(8'h04, 32'h8001_0100);
    rd(8'h04, v); check("R4 locked value", v, 32'h8001_0100);
    wr(8'h04, 32'h0);
    rd(8'h04, v); check("R4 write ignored", v, 32'h8001_0100);
    src[0] = 1'b1; cycles(6);
    check("R4 locked still works", status, 2'b01);
    src[0] = 1'b0;
    do_reset();
    rd(8'h04, v); check("R4 reset unlocks", v, 0);
    check("R1 status after reset", status, 2'b00);
    wr(8'h04, 32'h0000_0100);
    rd(8'h04, v); check("R4 writable again", v, 32'h0000_0100);
  endtask

  initial begin
    t_reset_regs();
    t_wp();
    t_edge();
    t_disable();
    t_level();
    t_filter();
    t_lock();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule